// File: doc/BRIEF.md
# Serial Flash Slave Pin Front-End

This block sits between the package pins of a serial flash memory and its command decoder. It runs on the chip's system clock and oversamples the select, serial clock and four data pins through a short synchronizer. From these it detects serial-clock edges. On each rising edge it captures one, two or four data bits, depending on the lane width the decoder asks for. It passes them on with a one-cycle valid strobe and a bit position within the current byte. On falling edges it drives outgoing bits from the decoder onto the right pins and enables only those pin drivers.

The block gates everything on a proper select. After reset, nothing is accepted until the select line has been seen high and then low. A rising select abandons any partial byte. Two of the data pins have a second use. One is an active-low write-protect input, and the other is an active-low pause input that freezes a transfer in mid-byte without losing its place. When the quad-enable input is set, both pins become plain data lanes and lose those control roles. The block also reports whether a status-register write is currently allowed. It works this out from the write-protect pin, the status-protect input and the quad-enable input.

Top module: `spi_flash_pin_fe`

## Requirements
- R1: While the device is not selected (select high, or no high-to-low select seen since reset), every bit of `io_oe` is 0.
- R2: After reset, no `rx_valid` pulse occurs until `cs_n` has been seen high and then low; clock edges before that are ignored.
- R3: Each rising `sclk` edge while selected and not paused gives exactly one `rx_valid` pulse. The lanes land in `rx_bits` as follows: single width puts `io_in[0]` in bit 0 with the other bits 0; dual width puts `{io_in[1],io_in[0]}` in bits 1:0; quad width puts `io_in[3:0]` in bits 3:0.
- R4: `rx_bit_pos` is 0 after reset and advances by the lane width (1, 2 or 4) on every capture, modulo 8.
- R5: Output data changes only on falling `sclk` edges and is enabled only while `tx_phase` is 1. Single width drives `tx_data[0]` on `io_out[1]` with `io_oe`=0010. Dual width drives `tx_data[1:0]` on `io_out[1:0]` with `io_oe`=0011. Quad width drives `tx_data[3:0]` on all pins with `io_oe`=1111.
- R6: `lane_req` encodes 0 as single, 1 as dual, 2 as quad and 3 as single. A quad request while `quad_en`=0 is served as single width.
- R7: With `quad_en`=0, `io_in[3]` sampled low at a falling `sclk` edge while selected pauses the transfer. While paused, rising edges give no `rx_valid`, `io_oe` is 0 and `rx_bit_pos` holds. `io_in[3]` sampled high at a later falling edge resumes the transfer at the same bit position.
- R8: With `quad_en`=1, `io_in[3]` never pauses the transfer and `io_in[2]` has no effect on `status_wr_ok`.
- R9: `status_wr_ok` is 0 exactly when `srp`=1, `io_in[2]`=0 and `quad_en`=0; otherwise it is 1.
- R10: A rising `cs_n` discards any partial byte, returns `rx_bit_pos` to 0 and ends any pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select pin |
| sclk | input | 1 | Serial clock pin |
| io_in | input | 4 | Pin input values: 0 data-in, 1 data-out, 2 write-protect/lane 2, 3 pause/lane 3 |
| io_out | output | 4 | Pin output values |
| io_oe | output | 4 | Per-pin output enable |
| quad_en | input | 1 | Quad-enable bit; repurposes pins 2 and 3 as data lanes |
| srp | input | 1 | Status-register-protect bit |
| lane_req | input | 2 | Lane width requested by the decoder |
| tx_phase | input | 1 | Decoder is in an output phase |
| tx_data | input | 4 | Bits to drive on the next falling edge |
| rx_bits | output | 4 | Bits captured on the last rising edge |
| rx_valid | output | 1 | One-cycle strobe for `rx_bits` |
| rx_bit_pos | output | 3 | Bit position within the current byte |
| status_wr_ok | output | 1 | Status-register write permitted |

## Verification
The hardest situation to reach is a pause that starts and ends in the middle of a byte, with clock pulses arriving during the pause. The pause pin only counts at a falling edge. So the stimulus lowers it while the clock is high on the fourth bit, so that the following falling edge enters the pause. It then issues clock pulses carrying junk, and raises the pin during the high phase of one more pulse. The remaining four bits must then complete the original byte. A second hard case is a select held low straight through reset. The bench keeps `cs_n` low from time zero and clocks a whole byte that must be ignored.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int IO_LANES = 4;

    typedef enum logic [1:0] {
        LANE_X1  = 2'd0,
        LANE_X2  = 2'd1,
        LANE_X4  = 2'd2,
        LANE_RSV = 2'd3
    } lane_mode_e;

    typedef struct packed {
        logic [IO_LANES-1:0] bits;
        logic                valid;
    } rx_beat_t;

    // Quad width is only honoured when the quad-enable bit is set.
    function automatic lane_mode_e resolve_mode(logic [1:0] req, logic quad_ok);
        case (req)
            2'd1:    return LANE_X2;
            2'd2:    return quad_ok ? LANE_X4 : LANE_X1;
            default: return LANE_X1;
        endcase
    endfunction

    function automatic logic [IO_LANES-1:0] rx_mask(lane_mode_e m);
        case (m)
            LANE_X2: return 4'b0011;
            LANE_X4: return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic logic [IO_LANES-1:0] tx_mask(lane_mode_e m);
        case (m)
            LANE_X2: return 4'b0011;
            LANE_X4: return 4'b1111;
            default: return 4'b0010;
        endcase
    endfunction

    function automatic int unsigned lane_step(lane_mode_e m);
        case (m)
            LANE_X2: return 2;
            LANE_X4: return 4;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[s] <= '0;
                end else if (s == 0) begin
                    stage[s] <= d;
                end else begin
                    stage[s] <= stage[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_fe_edge.sv
module spi_fe_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_d;

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= 1'b0;
        else     lvl_d <= lvl;
    end

    assign rise = lvl & ~lvl_d;
    assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic cs_s,
    input  logic sclk_fall,
    input  logic hold_n_s,
    input  logic quad_en,
    output logic armed,
    output logic selected,
    output logic cs_rise,
    output logic paused
);
    logic cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d  <= 1'b0;
            armed <= 1'b0;
        end else begin
            cs_d <= cs_s;
            if (cs_s) armed <= 1'b1;
        end
    end

    assign cs_rise  = cs_s & ~cs_d;
    assign selected = armed & ~cs_s;

    // Pause state changes only on a falling serial-clock edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            paused <= 1'b0;
        end else if (cs_rise || !selected || quad_en) begin
            paused <= 1'b0;
        end else if (sclk_fall) begin
            paused <= ~hold_n_s;
        end
    end

    AST_QUAD_NO_PAUSE: assert property (@(posedge clk) disable iff (rst)
        quad_en |=> !paused); // R8

    AST_ABORT_UNPAUSE: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> !paused); // R10
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift
    import spi_fe_pkg::*;
#(
    parameter int POS_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk_rise,
    input  logic                sclk_fall,
    input  logic                take,
    input  logic                cs_rise,
    input  lane_mode_e          mode,
    input  logic [IO_LANES-1:0] io_s,
    input  logic [IO_LANES-1:0] tx_data,
    input  logic                tx_phase,
    output rx_beat_t            beat,
    output logic [POS_W-1:0]    bit_pos,
    output logic [IO_LANES-1:0] io_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.valid <= sclk_rise & take;
            if (sclk_rise && take) beat.bits <= io_s & rx_mask(mode);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cs_rise) begin
            bit_pos <= '0;
        end else if (sclk_rise && take) begin
            bit_pos <= bit_pos + POS_W'(lane_step(mode));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            io_out <= '0;
        end else if (sclk_fall && take && tx_phase) begin
            if (mode == LANE_X1 || mode == LANE_RSV)
                io_out <= {2'b00, tx_data[0], 1'b0};
            else
                io_out <= tx_data & tx_mask(mode);
        end
    end

    AST_ABORT_POS: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> bit_pos == '0); // R10

    AST_POS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(bit_pos) || $past(cs_rise)); // R7
endmodule

// File: rtl/spi_flash_pin_fe.sv
module spi_flash_pin_fe
    import spi_fe_pkg::*;
#(
    parameter int BYTE_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cs_n,
    input  logic                        sclk,
    input  logic [3:0]                  io_in,
    output logic [3:0]                  io_out,
    output logic [3:0]                  io_oe,
    input  logic                        quad_en,
    input  logic                        srp,
    input  logic [1:0]                  lane_req,
    input  logic                        tx_phase,
    input  logic [3:0]                  tx_data,
    output logic [3:0]                  rx_bits,
    output logic                        rx_valid,
    output logic [$clog2(BYTE_BITS)-1:0] rx_bit_pos,
    output logic                        status_wr_ok
);
    localparam int POS_W  = $clog2(BYTE_BITS);
    localparam int SYNC_W = IO_LANES + 2;

    logic [SYNC_W-1:0]   pins_s;
    logic [IO_LANES-1:0] io_s;
    logic                cs_s, sclk_s;
    logic                sclk_rise, sclk_fall;
    logic                armed, selected, cs_rise, paused;
    lane_mode_e          mode;
    rx_beat_t            beat;

    spi_fe_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, io_in}),
        .q   (pins_s)
    );

    assign {cs_s, sclk_s, io_s} = pins_s;

    spi_fe_edge u_sclk_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sclk_s),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    spi_fe_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_s      (cs_s),
        .sclk_fall (sclk_fall),
        .hold_n_s  (io_s[3]),
        .quad_en   (quad_en),
        .armed     (armed),
        .selected  (selected),
        .cs_rise   (cs_rise),
        .paused    (paused)
    );

    assign mode = resolve_mode(lane_req, quad_en);

    spi_fe_shift #(.POS_W(POS_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .take      (selected & ~paused),
        .cs_rise   (cs_rise),
        .mode      (mode),
        .io_s      (io_s),
        .tx_data   (tx_data),
        .tx_phase  (tx_phase),
        .beat      (beat),
        .bit_pos   (rx_bit_pos),
        .io_out    (io_out)
    );

    assign rx_bits  = beat.bits;
    assign rx_valid = beat.valid;

    // Raw select also gates the drivers so release does not wait for the synchronizer.
    assign io_oe = (!cs_n && selected && !paused && tx_phase) ? tx_mask(mode) : '0;

    assign status_wr_ok = ~(srp & ~io_s[2] & ~quad_en);

    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (rst)
        !selected |-> io_oe == '0); // R1

    AST_NO_RX_UNARMED: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !rx_valid); // R2

    AST_PAUSE_NO_RX: assert property (@(posedge clk) disable iff (rst)
        paused |=> !rx_valid); // R7

    AST_RX_ONLY_OE: assert property (@(posedge clk) disable iff (rst)
        !tx_phase |-> io_oe == '0); // R5

    AST_X1_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && mode == LANE_X1 && $stable(mode)) |-> rx_bits[3:1] == 3'b000); // R3
endmodule

// File: tb/spi_flash_pin_fe_bench.sv
module spi_flash_pin_fe_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b0;
    logic       sclk = 1'b0;
    logic [3:0] pin = 4'b1100;
    logic       quad_en = 1'b0;
    logic       srp = 1'b0;
    logic [1:0] lane_req = 2'd0;
    logic       tx_phase = 1'b0;
    logic [3:0] tx_data = 4'd0;
    logic [3:0] io_out, io_oe, rx_bits;
    logic       rx_valid, status_wr_ok;
    logic [2:0] rx_bit_pos;

    int checks = 0;
    int errors = 0;
    int rx_cnt = 0;
    int cap_w  = 1;
    logic [31:0] cap = '0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_flash_pin_fe u_spi_flash_pin_fe (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .io_in(pin),
        .io_out(io_out), .io_oe(io_oe), .quad_en(quad_en), .srp(srp),
        .lane_req(lane_req), .tx_phase(tx_phase), .tx_data(tx_data),
        .rx_bits(rx_bits), .rx_valid(rx_valid), .rx_bit_pos(rx_bit_pos),
        .status_wr_ok(status_wr_ok)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt = rx_cnt + 1;
            cap = (cap << cap_w) | 32'(rx_bits);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_cap(input int w);
        cap_w = w; cap = '0; rx_cnt = 0;
    endtask

    task automatic pulse(input logic [3:0] d, input logic hold_late);
        pin = d; tick(4);
        sclk = 1'b1; tick(4);
        pin[3] = hold_late; tick(4);
        sclk = 1'b0; tick(4);
    endtask

    task automatic send_x1(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) pulse({pin[3:2], 1'b0, b[i]}, pin[3]);
    endtask

    task automatic reselect();
        cs_n = 1'b1; tick(4);
        cs_n = 1'b0; tick(4);
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", 32'(io_oe), 0);
        chk("R4 pos after reset", 32'(rx_bit_pos), 0);
        chk("R3 no strobe after reset", 32'(rx_valid), 0);
    endtask

    task automatic t_first_select();
        clr_cap(1);
        send_x1(8'hFF);
        chk("R2 ignored before first select", rx_cnt, 0);
        reselect();
        clr_cap(1);
        send_x1(8'hA5);
        chk("R2 count after select", rx_cnt, 8);
        chk("R3 single byte", cap, 32'hA5);
        chk("R4 pos wraps", 32'(rx_bit_pos), 0);
    endtask

    task automatic t_abort();
        reselect();
        clr_cap(1);
        pulse(4'b1101, 1'b1); pulse(4'b1100, 1'b1); pulse(4'b1101, 1'b1);
        chk("R4 pos after 3 bits", 32'(rx_bit_pos), 3);
        cs_n = 1'b1; tick(4);
        chk("R10 pos cleared by deselect", 32'(rx_bit_pos), 0);
        cs_n = 1'b0; tick(4);
    endtask

    task automatic t_dual();
        logic [7:0] b = 8'hB4;
        reselect();
        lane_req = 2'd1; clr_cap(2);
        pulse({2'b11, b[7:6]}, 1'b1);
        chk("R4 dual step", 32'(rx_bit_pos), 2);
        pulse({2'b11, b[5:4]}, 1'b1);
        pulse({2'b11, b[3:2]}, 1'b1);
        pulse({2'b11, b[1:0]}, 1'b1);
        chk("R3 dual strobes", rx_cnt, 4);
        chk("R3 dual byte", cap, 32'hB4);
        lane_req = 2'd0;
    endtask

    task automatic t_quad_fallback();
        reselect();
        lane_req = 2'd2; quad_en = 1'b0; clr_cap(1);
        send_x1(8'h3C);
        chk("R6 fallback strobes", rx_cnt, 8);
        chk("R6 fallback byte", cap, 32'h3C);
        lane_req = 2'd0;
    endtask

    task automatic t_quad_wp();
        reselect();
        quad_en = 1'b1; srp = 1'b1; lane_req = 2'd2; clr_cap(4);
        pin = 4'b0000; tick(4);
        chk("R8 wp ignored in quad", 32'(status_wr_ok), 1);
        pulse(4'h2, 1'b0);
        pulse(4'h9, 1'b1);
        chk("R8 low lane3 no pause", rx_cnt, 2);
        chk("R3 quad nibbles", cap, 32'h29);
        chk("R4 quad pos", 32'(rx_bit_pos), 0);
        quad_en = 1'b0; lane_req = 2'd0; pin = 4'b1100; tick(4);
    endtask

    task automatic t_status();
        quad_en = 1'b0; srp = 1'b1; pin[2] = 1'b0; tick(4);
        chk("R9 protected", 32'(status_wr_ok), 0);
        pin[2] = 1'b1; tick(4);
        chk("R9 wp high", 32'(status_wr_ok), 1);
        srp = 1'b0; pin[2] = 1'b0; tick(4);
        chk("R9 srp clear", 32'(status_wr_ok), 1);
        pin[2] = 1'b1; tick(4);
    endtask

    task automatic t_hold();
        reselect();
        clr_cap(1);
        pulse(4'b1101, 1'b1); pulse(4'b1101, 1'b1);
        pulse(4'b1100, 1'b1); pulse(4'b1101, 1'b0);
        chk("R7 bits before pause", rx_cnt, 4);
        pulse(4'b0101, 1'b0); pulse(4'b0100, 1'b0); pulse(4'b0101, 1'b0);
        chk("R7 no strobes while paused", rx_cnt, 4);
        chk("R7 pos held", 32'(rx_bit_pos), 4);
        tx_phase = 1'b1; tick(2);
        chk("R7 drivers off while paused", 32'(io_oe), 0);
        tx_phase = 1'b0;
        pulse(4'b0101, 1'b1);
        chk("R7 release pulse ignored", rx_cnt, 4);
        pulse(4'b1100, 1'b1); pulse(4'b1101, 1'b1);
        pulse(4'b1101, 1'b1); pulse(4'b1100, 1'b1);
        chk("R7 resumed count", rx_cnt, 8);
        chk("R7 resumed byte", cap, 32'hD6);
    endtask

    task automatic t_tx();
        reselect();
        tx_phase = 1'b1; tx_data = 4'b0001; lane_req = 2'd0;
        pulse(4'b1100, 1'b1);
        chk("R5 single oe", 32'(io_oe), 32'h2);
        chk("R5 single out", 32'(io_out), 32'h2);
        quad_en = 1'b1; lane_req = 2'd2; tx_data = 4'b1010;
        tick(2);
        chk("R5 no change before fall", 32'(io_out), 32'h2);
        pulse(4'b1100, 1'b1);
        chk("R5 quad oe", 32'(io_oe), 32'hF);
        chk("R5 quad out", 32'(io_out), 32'hA);
        cs_n = 1'b1; #1;
        chk("R1 deselect releases pins", 32'(io_oe), 0);
        tick(4);
        tx_phase = 1'b0; quad_en = 1'b0; lane_req = 2'd0;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_first_select();
        t_abort();
        t_dual();
        t_quad_fallback();
        t_quad_wp();
        t_status();
        t_hold();
        t_tx();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired (R1..all pending)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule